// File: doc/BRIEF.md
# Serial Control-Register Loader

This block is a write-only serial slave that receives configuration words for an imaging front end. A host drives three wires: a serial clock, a data line and an active-low frame enable. While the enable is low, the block samples the data line on each rising serial-clock edge and shifts the bit into a frame register. When the enable returns high, the block checks the frame length. A frame of the correct length is decoded and its payload is copied into one of four parallel control registers. These registers drive downstream logic continuously.

The three serial pins are asynchronous to the system clock. Each pin is brought into the system domain through a synchronizer chain, and the edges are detected after synchronization. There is no data stream at the block's edge, so the outputs are plain level signals with no valid/ready handshake. The block also keeps a sticky flag. The flag is set whenever the clamp code is rewritten and cleared when the gain code is rewritten next, so the host can see that a gain refresh is still owed.

Top module: `scfg_top`

## Requirements
- R1: After reset, the clamp, cut-off and gain codes are all zero, `smp_low` is 0, `clp_high` is 1, `adck_rise` is 1 and `gain_stale` is 0.
- R2: A frame holds 12 bits, sent most significant bit first: the 2-bit selector comes first (high bit, then low bit), followed by payload bits 9 down to 0.
- R3: Selector 00 loads all 10 payload bits into `clamp_code`.
- R4: Selector 01 loads payload bits 3..0 into `bw_code`; payload bits 9..4 have no effect.
- R5: Selector 10 loads all 10 payload bits into `gain_code`.
- R6: Selector 11 sets `smp_low` from payload bit 0, `clp_high` from bit 1 and `adck_rise` from bit 2; payload bits 9..3 have no effect.
- R7: A register loads only when the enable rises after exactly 12 rising serial-clock edges were seen while the enable was low. A frame with fewer or more edges is discarded and no output changes.
- R8: A valid frame changes only the register its selector names; every other output keeps its value.
- R9: `gain_stale` goes to 1 on each clamp-code load and goes to 0 on the next gain-code load. Loads of the cut-off and edge registers leave it unchanged.
- R10: Serial-clock edges that arrive while the enable is high are ignored; they neither load a register nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on serial-clock rise |
| ser_en_n | input | 1 | Active-low frame enable, asynchronous |
| clamp_code | output | 10 | Converter clamp reference code |
| bw_code | output | 4 | Track/hold bandwidth cut-off code |
| gain_code | output | 10 | Amplifier gain code |
| smp_low | output | 1 | Sample pulses act on low level when 1 |
| clp_high | output | 1 | Clamp pulses are active high when 1 |
| adck_rise | output | 1 | Converter clock acts on rising edge when 1 |
| gain_stale | output | 1 | Gain must be rewritten after a clamp change |

## Verification
The bench builds the block with a three-stage synchronizer instead of the default two. This checks that the decode and the load timing depend only on the synchronized edges and not on a fixed pipeline depth. The payload and cut-off widths stay at their defaults, so the bench can drive all-ones patterns into the payload bits that are ignored. It also sends frames one bit short and one bit long, and toggles the serial clock while the enable is high, to confirm that these are discarded.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  typedef enum logic [1:0] {
    SEL_CLAMP = 2'b00,
    SEL_BW    = 2'b01,
    SEL_GAIN  = 2'b10,
    SEL_EDGE  = 2'b11
  } sel_e;

  localparam int SEL_W  = 2;
  localparam int EDGE_W = 3;

  // edge control word: bit2 converter clock rising, bit1 clamp active high,
  // bit0 sample pulses low-level
  typedef struct packed {
    logic adck_rise;
    logic clp_high;
    logic smp_low;
  } edge_t;

  localparam edge_t EDGE_RST = '{adck_rise: 1'b1, clp_high: 1'b1, smp_low: 1'b0};
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int             WIDTH   = 3,
  parameter int             STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d_async;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scfg_frame.sv
module scfg_frame #(
  parameter int DATA_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sclk,
  input  logic              s_sdat,
  input  logic              s_en_n,
  output logic              wr_vld,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [DATA_W-1:0] wr_data
);
  localparam int FRAME_W = SEL_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_q, en_q;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               sclk_rise, en_fall, en_rise;

  assign sclk_rise = s_sclk & ~sclk_q;
  assign en_fall   = ~s_en_n & en_q;
  assign en_rise   = s_en_n & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      sclk_q <= s_sclk;
      en_q   <= s_en_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (en_fall) begin
      cnt <= '0;
    end else if (sclk_rise && !s_en_n) begin
      shreg <= {shreg[FRAME_W-2:0], s_sdat};
      if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_vld <= 1'b0;
    else        wr_vld <= en_rise && (cnt == CNT_FULL);
  end

  assign wr_sel  = shreg[FRAME_W-1 -: SEL_W];
  assign wr_data = shreg[DATA_W-1:0];
endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BW_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] clamp_q,
  output logic [BW_W-1:0]   bw_q,
  output logic [DATA_W-1:0] gain_q,
  output edge_t             edge_q,
  output logic              stale_q
);
  logic hit_clamp, hit_bw, hit_gain, hit_edge;

  assign hit_clamp = wr_vld && (sel_e'(wr_sel) == SEL_CLAMP);
  assign hit_bw    = wr_vld && (sel_e'(wr_sel) == SEL_BW);
  assign hit_gain  = wr_vld && (sel_e'(wr_sel) == SEL_GAIN);
  assign hit_edge  = wr_vld && (sel_e'(wr_sel) == SEL_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= '0;
      bw_q    <= '0;
      gain_q  <= '0;
      edge_q  <= EDGE_RST;
      stale_q <= 1'b0;
    end else begin
      if (hit_clamp) begin
        clamp_q <= wr_data;
        stale_q <= 1'b1;
      end
      if (hit_bw)   bw_q <= wr_data[BW_W-1:0];
      if (hit_gain) begin
        gain_q  <= wr_data;
        stale_q <= 1'b0;
      end
      if (hit_edge) edge_q <= edge_t'(wr_data[EDGE_W-1:0]);
    end
  end
endmodule

// File: rtl/scfg_top.sv
module scfg_top
  import scfg_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int BW_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_en_n,
  output logic [DATA_W-1:0] clamp_code,
  output logic [BW_W-1:0]   bw_code,
  output logic [DATA_W-1:0] gain_code,
  output logic              smp_low,
  output logic              clp_high,
  output logic              adck_rise,
  output logic              gain_stale
);
  logic [2:0]        pins_s;
  logic              wr_vld;
  logic [SEL_W-1:0]  wr_sel;
  logic [DATA_W-1:0] wr_data;
  edge_t             edge_q;

  // bit2 enable (idles high), bit1 data, bit0 clock
  scfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ser_en_n, ser_dat, ser_clk}),
    .q_sync(pins_s)
  );

  scfg_frame #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_frame (
    .clk(clk), .rst_n(rst_n),
    .s_sclk(pins_s[0]), .s_sdat(pins_s[1]), .s_en_n(pins_s[2]),
    .wr_vld(wr_vld), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  scfg_regs #(.DATA_W(DATA_W), .BW_W(BW_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(wr_vld), .wr_sel(wr_sel), .wr_data(wr_data),
    .clamp_q(clamp_code), .bw_q(bw_code), .gain_q(gain_code),
    .edge_q(edge_q), .stale_q(gain_stale)
  );

  assign smp_low   = edge_q.smp_low;
  assign clp_high  = edge_q.clp_high;
  assign adck_rise = edge_q.adck_rise;
endmodule

// File: rtl/scfg_top_chk.sv
module scfg_top_chk #(
  parameter int DATA_W = 10,
  parameter int BW_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_vld,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] clamp_code,
  input logic [BW_W-1:0]   bw_code,
  input logic [DATA_W-1:0] gain_code,
  input logic              smp_low,
  input logic              clp_high,
  input logic              adck_rise,
  input logic              gain_stale
);
  // R7
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !wr_vld);

  // R8
  clamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_sel == 2'b00) |=> $stable(clamp_code));

  // R8
  bw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_sel == 2'b01) |=> $stable(bw_code));

  // R8
  gain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_sel == 2'b10) |=> $stable(gain_code));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_sel == 2'b11) |=> $stable({adck_rise, clp_high, smp_low}));

  // R9
  stale_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_sel == 2'b00) |=> gain_stale);

  // R9
  stale_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_vld && wr_sel == 2'b10) |=> !gain_stale);

  // R9
  stale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_vld && wr_sel[0] == 1'b0) |=> $stable(gain_stale));
endmodule

bind scfg_top scfg_top_chk #(.DATA_W(DATA_W), .BW_W(BW_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .wr_sel(wr_sel),
  .clamp_code(clamp_code), .bw_code(bw_code), .gain_code(gain_code),
  .smp_low(smp_low), .clp_high(clp_high), .adck_rise(adck_rise),
  .gain_stale(gain_stale)
);

// File: tb/test_scfg_top.sv
module test_scfg_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic [9:0] clamp_code, gain_code;
  logic [3:0] bw_code;
  logic smp_low, clp_high, adck_rise, gain_stale;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // expected model
  logic [9:0] e_clamp = '0, e_gain = '0;
  logic [3:0] e_bw = '0;
  logic e_smp = 1'b0, e_clp = 1'b1, e_adck = 1'b1, e_stale = 1'b0;

  always #10 clk = ~clk;

  scfg_top #(.DATA_W(10), .BW_W(4), .SYNC_STAGES(3)) i_scfg_top (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .clamp_code(clamp_code), .bw_code(bw_code),
    .gain_code(gain_code), .smp_low(smp_low), .clp_high(clp_high),
    .adck_rise(adck_rise), .gain_stale(gain_stale)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " clamp"}, clamp_code, e_clamp);
    chk({req, " bw"}, bw_code, e_bw);
    chk({req, " gain"}, gain_code, e_gain);
    chk({req, " smp_low"}, smp_low, e_smp);
    chk({req, " clp_high"}, clp_high, e_clp);
    chk({req, " adck_rise"}, adck_rise, e_adck);
    chk({req, " stale"}, gain_stale, e_stale);
  endtask

  task automatic waitc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // send nbits of word, most significant of those first
  task automatic send(input int nbits, input logic [15:0] word);
    @(negedge clk);
    ser_en_n = 1'b0;
    waitc(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      ser_dat = word[i];
      waitc(4);
      ser_clk = 1'b1;
      waitc(4);
      ser_clk = 1'b0;
      waitc(2);
    end
    waitc(2);
    ser_en_n = 1'b1;
    waitc(12);
  endtask

  task automatic t_reset;
    chk_all("R1");
  endtask

  task automatic t_clamp;
    send(12, {4'h0, 2'b00, 10'h2A5});
    e_clamp = 10'h2A5; e_stale = 1'b1;
    chk_all("R3 R2 R9");
  endtask

  task automatic t_bw;
    send(12, {4'h0, 2'b01, 10'h3F9});
    e_bw = 4'h9;
    chk_all("R4 R8 R9");
  endtask

  task automatic t_gain;
    send(12, {4'h0, 2'b10, 10'h155});
    e_gain = 10'h155; e_stale = 1'b0;
    chk_all("R5 R9");
  endtask

  task automatic t_edge;
    send(12, {4'h0, 2'b11, 10'h3F9});
    e_smp = 1'b1; e_clp = 1'b0; e_adck = 1'b0;
    chk_all("R6 R8");
    send(12, {4'h0, 2'b11, 10'h006});
    e_smp = 1'b0; e_clp = 1'b1; e_adck = 1'b1;
    chk_all("R6");
  endtask

  task automatic t_bad_len;
    send(11, {5'h0, 1'b0, 10'h3FF});
    chk_all("R7 short");
    send(13, {3'h0, 1'b1, 2'b00, 10'h0F0});
    chk_all("R7 long");
    send(0, 16'h0);
    chk_all("R7 empty");
  endtask

  task automatic t_idle_clk;
    ser_dat = 1'b1;
    for (int i = 0; i < 14; i++) begin
      waitc(4); ser_clk = 1'b1; waitc(4); ser_clk = 1'b0;
    end
    waitc(12);
    chk_all("R10");
    send(12, {4'h0, 2'b00, 10'h001});
    e_clamp = 10'h001; e_stale = 1'b1;
    chk_all("R10 R3 after idle");
  endtask

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_clamp();
    t_bw();
    t_gain();
    t_edge();
    t_bad_len();
    t_idle_clk();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule